// File: doc/BRIEF.md
# Multichannel Slot-Mask Channelizer

This block sits behind one serial port of a time-slot assigner and splits the stream of bytes from the slots routed to that port into up to 64 logical channels. A slot counter numbers the routed slots from the frame-start indication onward. Each channel owns slot positions through its own 64-bit receive mask and 64-bit transmit mask. Bit n of a mask names the n-th routed slot, not slot n of the TDM line.

On receive, every byte is tagged with the number of the channel that owns its slot position, or dropped if no running channel owns it. On transmit, each slot strobe becomes a byte request to the owning channel. The byte that comes back goes out one cycle later. A slot with no owner is filled with 0xFF. A channel in transparent mode may have its bytes bit-reversed in both directions. A channel in HDLC mode passes its bytes through untouched and marks them with a mode tag for a downstream framer.

Top module: `chz_channelizer`

## Requirements
- R1: While and directly after reset, `ch_rx_valid`, `tx_req` and `tx_out_valid` are low, and both slot positions restart at 0.
- R2: A receive strobe yields `ch_rx_valid` high one cycle later, with `ch_rx_chan` set to the lowest-numbered running channel whose receive mask claims the slot position. When several channels claim that position, the lowest number wins.
- R3: The slot position is 0 for a strobe that carries the frame-start flag. Each later strobe in the same direction adds 1. A frame-start in the middle of a frame restarts the count at 0.
- R4: A receive slot claimed by no running channel produces no `ch_rx_valid`.
- R5: A channel whose run bit is low for a direction neither receives bytes nor is asked for bytes. A higher-numbered running claimant then takes the slot.
- R6: The mode bit selects the channel's mode: 0 means transparent and 1 means HDLC. The output byte is bit-reversed (bit 7 swapped with bit 0, and so on) only when the mode is transparent and the reverse bit is 1. An HDLC channel ignores its reverse bit and carries its mode tag: `ch_rx_hdlc` is 1 on receive.
- R7: A transmit strobe raises `tx_req` with `tx_req_chan` one cycle later. `tx_out_valid` follows one cycle after that, carrying `tx_src_byte` as sampled in the request cycle, after the R6 transform.
- R8: A transmit slot with no running owner raises no `tx_req` and sends 0xFF.
- R9: Slot positions at or beyond 64 (with no new frame-start) are owned by no channel.
- R10: The receive and transmit positions count independently, and both directions may strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rx_mask | input | NCH*NSLOT | Receive slot masks, channel c in bits [c*NSLOT +: NSLOT] |
| cfg_tx_mask | input | NCH*NSLOT | Transmit slot masks, same layout |
| cfg_hdlc | input | NCH | Mode per channel: 1 = HDLC, 0 = transparent |
| cfg_rev | input | NCH | Bit-order reversal per channel (transparent only) |
| cfg_rx_run | input | NCH | Receive start/stop per channel |
| cfg_tx_run | input | NCH | Transmit start/stop per channel |
| rx_strobe | input | 1 | A routed receive slot byte is present |
| rx_fs | input | 1 | This receive slot is position 0 |
| rx_byte | input | 8 | Receive slot byte |
| ch_rx_valid | output | 1 | Tagged receive byte valid |
| ch_rx_chan | output | CHW | Owning channel |
| ch_rx_byte | output | 8 | Byte after the mode transform |
| ch_rx_hdlc | output | 1 | Mode tag of the owner |
| tx_strobe | input | 1 | A routed transmit slot needs a byte |
| tx_fs | input | 1 | This transmit slot is position 0 |
| tx_req | output | 1 | Byte request to a channel |
| tx_req_chan | output | CHW | Channel asked for the byte |
| tx_src_byte | input | 8 | Byte returned by the requested channel |
| tx_out_valid | output | 1 | Transmit slot byte valid |
| tx_out_byte | output | 8 | Transmit slot byte |

## Verification
Receive tagging and transmit requesting can fall in the same cycle, each with its own frame-start. The bench raises both strobes and both frame-start flags on one clock. After that it sends extra receive-only slots, so the two positions drift apart. It then judges the next transmit slot by the owner of the transmit position alone. Overlapping claims, stopped channels and position overflow past 64 are each provoked separately, and the expected owner is derived from the masks the bench loaded.

// File: rtl/chz_pkg.sv
package chz_pkg;

    typedef logic [7:0] byte_t;

    typedef enum logic {
        MODE_TRANSP = 1'b0,
        MODE_HDLC   = 1'b1
    } lane_mode_e;

    localparam byte_t IDLE_FILL = 8'hFF;

    function automatic byte_t bit_flip(byte_t b);
        byte_t r;
        for (int i = 0; i < 8; i++) begin
            r[i] = b[7-i];
        end
        return r;
    endfunction

    // Reversal only in transparent mode; HDLC bytes pass untouched.
    function automatic byte_t lane_xform(byte_t b, lane_mode_e mode, logic rev);
        if (mode == MODE_TRANSP && rev) begin
            return bit_flip(b);
        end
        return b;
    endfunction

endpackage

// File: rtl/chz_slot_counter.sv
module chz_slot_counter #(
    parameter int NSLOT = 64,
    localparam int PW = $clog2(NSLOT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strobe,
    input  logic          fs,
    output logic [PW-1:0] pos_o
);
    logic [PW-1:0] cnt;

    assign pos_o = fs ? '0 : cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (strobe) begin
            if (pos_o == PW'(NSLOT)) begin
                cnt <= PW'(NSLOT);
            end else begin
                cnt <= pos_o + PW'(1);
            end
        end
    end

    assert_fs_restart_R3: assert property (@(posedge clk) disable iff (rst)
        (strobe && fs) |=> (cnt == PW'(1)));

    assert_overflow_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (strobe && !fs && cnt == PW'(NSLOT)) |=> (cnt == PW'(NSLOT)));

endmodule

// File: rtl/chz_owner_select.sv
module chz_owner_select #(
    parameter int NCH   = 64,
    parameter int NSLOT = 64,
    localparam int CHW = $clog2(NCH),
    localparam int PW  = $clog2(NSLOT + 1),
    localparam int SW  = $clog2(NSLOT)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NCH*NSLOT-1:0] masks,
    input  logic [NCH-1:0]       run,
    input  logic [PW-1:0]        pos,
    output logic                 hit,
    output logic [CHW-1:0]       chan
);
    logic           slot_ok;
    logic [SW-1:0]  idx;
    logic [NCH-1:0] claim;

    assign slot_ok = (pos < PW'(NSLOT));
    assign idx     = pos[SW-1:0];

    for (genvar c = 0; c < NCH; c++) begin : g_claim
        logic [NSLOT-1:0] row;
        assign row      = masks[c*NSLOT +: NSLOT];
        assign claim[c] = slot_ok & run[c] & row[idx];
    end

    always_comb begin
        hit  = 1'b0;
        chan = '0;
        for (int c = NCH - 1; c >= 0; c--) begin
            if (claim[c]) begin
                hit  = 1'b1;
                chan = CHW'(c);
            end
        end
    end

    assert_lowest_wins_R2: assert property (@(posedge clk) disable iff (rst)
        hit |-> ((claim << (NCH - int'(chan))) == '0));

    assert_stopped_skipped_R5: assert property (@(posedge clk) disable iff (rst)
        hit |-> run[chan]);

    assert_past_end_unowned_R9: assert property (@(posedge clk) disable iff (rst)
        (pos >= PW'(NSLOT)) |-> !hit);

endmodule

// File: rtl/chz_rx_path.sv
module chz_rx_path
    import chz_pkg::*;
#(
    parameter int NCH = 64,
    localparam int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           strobe,
    input  byte_t          in_byte,
    input  logic           hit,
    input  logic [CHW-1:0] chan,
    input  logic [NCH-1:0] cfg_hdlc,
    input  logic [NCH-1:0] cfg_rev,
    output logic           out_valid,
    output logic [CHW-1:0] out_chan,
    output byte_t          out_byte,
    output logic           out_hdlc
);
    lane_mode_e mode;
    assign mode = lane_mode_e'(cfg_hdlc[chan]);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_chan  <= '0;
            out_byte  <= '0;
            out_hdlc  <= 1'b0;
        end else begin
            out_valid <= strobe & hit;
            if (strobe && hit) begin
                out_chan <= chan;
                out_byte <= lane_xform(in_byte, mode, cfg_rev[chan]);
                out_hdlc <= (mode == MODE_HDLC);
            end
        end
    end

    assert_valid_after_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(strobe));

    assert_unclaimed_dropped_R4: assert property (@(posedge clk) disable iff (rst)
        (strobe && !hit) |=> !out_valid);

    assert_hdlc_untouched_R6: assert property (@(posedge clk) disable iff (rst)
        (strobe && hit && cfg_hdlc[chan]) |=> (out_byte == $past(in_byte) && out_hdlc));

endmodule

// File: rtl/chz_tx_path.sv
module chz_tx_path
    import chz_pkg::*;
#(
    parameter int NCH = 64,
    localparam int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           strobe,
    input  logic           hit,
    input  logic [CHW-1:0] chan,
    input  logic [NCH-1:0] cfg_hdlc,
    input  logic [NCH-1:0] cfg_rev,
    output logic           tx_req,
    output logic [CHW-1:0] tx_req_chan,
    input  byte_t          src_byte,
    output logic           out_valid,
    output byte_t          out_byte
);
    logic s1_valid;
    logic s1_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid    <= 1'b0;
            s1_hit      <= 1'b0;
            tx_req_chan <= '0;
        end else begin
            s1_valid    <= strobe;
            s1_hit      <= strobe & hit;
            tx_req_chan <= hit ? chan : '0;
        end
    end

    assign tx_req = s1_valid & s1_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_byte  <= IDLE_FILL;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_byte <= tx_req ? lane_xform(src_byte, lane_mode_e'(cfg_hdlc[tx_req_chan]),
                                                cfg_rev[tx_req_chan])
                                   : IDLE_FILL;
            end
        end
    end

    assert_out_follows_req_R7: assert property (@(posedge clk) disable iff (rst)
        s1_valid |=> out_valid);

    assert_no_req_without_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> !tx_req);

    assert_idle_fill_R8: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && !s1_hit) |=> (out_byte == IDLE_FILL));

endmodule

// File: rtl/chz_channelizer.sv
module chz_channelizer
    import chz_pkg::*;
#(
    parameter int NCH   = 64,
    parameter int NSLOT = 64,
    localparam int CHW = $clog2(NCH),
    localparam int PW  = $clog2(NSLOT + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NCH*NSLOT-1:0] cfg_rx_mask,
    input  logic [NCH*NSLOT-1:0] cfg_tx_mask,
    input  logic [NCH-1:0]       cfg_hdlc,
    input  logic [NCH-1:0]       cfg_rev,
    input  logic [NCH-1:0]       cfg_rx_run,
    input  logic [NCH-1:0]       cfg_tx_run,
    input  logic                 rx_strobe,
    input  logic                 rx_fs,
    input  logic [7:0]           rx_byte,
    output logic                 ch_rx_valid,
    output logic [CHW-1:0]       ch_rx_chan,
    output logic [7:0]           ch_rx_byte,
    output logic                 ch_rx_hdlc,
    input  logic                 tx_strobe,
    input  logic                 tx_fs,
    output logic                 tx_req,
    output logic [CHW-1:0]       tx_req_chan,
    input  logic [7:0]           tx_src_byte,
    output logic                 tx_out_valid,
    output logic [7:0]           tx_out_byte
);
    logic [PW-1:0]  rx_pos, tx_pos;
    logic           rx_hit, tx_hit;
    logic [CHW-1:0] rx_own, tx_own;

    chz_slot_counter #(.NSLOT(NSLOT)) u_rx_cnt (
        .clk(clk), .rst(rst), .strobe(rx_strobe), .fs(rx_fs), .pos_o(rx_pos)
    );

    chz_slot_counter #(.NSLOT(NSLOT)) u_tx_cnt (
        .clk(clk), .rst(rst), .strobe(tx_strobe), .fs(tx_fs), .pos_o(tx_pos)
    );

    chz_owner_select #(.NCH(NCH), .NSLOT(NSLOT)) u_rx_sel (
        .clk(clk), .rst(rst), .masks(cfg_rx_mask), .run(cfg_rx_run),
        .pos(rx_pos), .hit(rx_hit), .chan(rx_own)
    );

    chz_owner_select #(.NCH(NCH), .NSLOT(NSLOT)) u_tx_sel (
        .clk(clk), .rst(rst), .masks(cfg_tx_mask), .run(cfg_tx_run),
        .pos(tx_pos), .hit(tx_hit), .chan(tx_own)
    );

    chz_rx_path #(.NCH(NCH)) u_rx (
        .clk(clk), .rst(rst), .strobe(rx_strobe), .in_byte(rx_byte),
        .hit(rx_hit), .chan(rx_own), .cfg_hdlc(cfg_hdlc), .cfg_rev(cfg_rev),
        .out_valid(ch_rx_valid), .out_chan(ch_rx_chan),
        .out_byte(ch_rx_byte), .out_hdlc(ch_rx_hdlc)
    );

    chz_tx_path #(.NCH(NCH)) u_tx (
        .clk(clk), .rst(rst), .strobe(tx_strobe), .hit(tx_hit), .chan(tx_own),
        .cfg_hdlc(cfg_hdlc), .cfg_rev(cfg_rev),
        .tx_req(tx_req), .tx_req_chan(tx_req_chan), .src_byte(tx_src_byte),
        .out_valid(tx_out_valid), .out_byte(tx_out_byte)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!ch_rx_valid && !tx_req && !tx_out_valid));

    assert_directions_apart_R10: assert property (@(posedge clk) disable iff (rst)
        (!rx_strobe && tx_strobe && tx_fs) |=> !ch_rx_valid);

endmodule

// File: tb/sim_chz_channelizer.sv
module sim_chz_channelizer;
    localparam int CLK_PERIOD = 10;
    localparam int NCH   = 64;
    localparam int NSLOT = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NCH*NSLOT-1:0] cfg_rx_mask = '0, cfg_tx_mask = '0;
    logic [NCH-1:0] cfg_hdlc = '0, cfg_rev = '0, cfg_rx_run = '0, cfg_tx_run = '0;
    logic rx_strobe = 0, rx_fs = 0, tx_strobe = 0, tx_fs = 0;
    logic [7:0] rx_byte = '0;
    logic ch_rx_valid, ch_rx_hdlc, tx_req, tx_out_valid;
    logic [5:0] ch_rx_chan, tx_req_chan;
    logic [7:0] ch_rx_byte, tx_src_byte, tx_out_byte;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chz_channelizer #(.NCH(NCH), .NSLOT(NSLOT)) u0 (
        .clk(clk), .rst(rst), .cfg_rx_mask(cfg_rx_mask), .cfg_tx_mask(cfg_tx_mask),
        .cfg_hdlc(cfg_hdlc), .cfg_rev(cfg_rev), .cfg_rx_run(cfg_rx_run),
        .cfg_tx_run(cfg_tx_run), .rx_strobe(rx_strobe), .rx_fs(rx_fs),
        .rx_byte(rx_byte), .ch_rx_valid(ch_rx_valid), .ch_rx_chan(ch_rx_chan),
        .ch_rx_byte(ch_rx_byte), .ch_rx_hdlc(ch_rx_hdlc), .tx_strobe(tx_strobe),
        .tx_fs(tx_fs), .tx_req(tx_req), .tx_req_chan(tx_req_chan),
        .tx_src_byte(tx_src_byte), .tx_out_valid(tx_out_valid),
        .tx_out_byte(tx_out_byte)
    );

    function automatic logic [7:0] src_of(logic [5:0] ch);
        return {2'b01, ch};
    endfunction

    assign tx_src_byte = src_of(tx_req_chan);

    function automatic logic [7:0] flip8(logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    function automatic logic [7:0] expect_byte(logic [7:0] b, int ch);
        return (!cfg_hdlc[ch] && cfg_rev[ch]) ? flip8(b) : b;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_cfg();
        cfg_rx_mask = '0; cfg_tx_mask = '0; cfg_hdlc = '0; cfg_rev = '0;
        cfg_rx_run = '1; cfg_tx_run = '1;
    endtask

    task automatic set_masks(int ch, logic [63:0] rxm, logic [63:0] txm);
        cfg_rx_mask[ch*NSLOT +: NSLOT] = rxm;
        cfg_tx_mask[ch*NSLOT +: NSLOT] = txm;
    endtask

    // ev < 0 means no byte expected
    task automatic rx_slot(logic fs, logic [7:0] d, int ech, string req);
        @(negedge clk);
        rx_strobe = 1; rx_fs = fs; rx_byte = d;
        @(negedge clk);
        rx_strobe = 0; rx_fs = 0;
        chk(req, ch_rx_valid, (ech >= 0));
        if (ech >= 0) begin
            chk(req, ch_rx_chan, ech);
            chk(req, ch_rx_byte, expect_byte(d, ech));
            chk(req, ch_rx_hdlc, cfg_hdlc[ech]);
        end
    endtask

    task automatic tx_slot(logic fs, int ech, string req);
        @(negedge clk);
        tx_strobe = 1; tx_fs = fs;
        @(negedge clk);
        tx_strobe = 0; tx_fs = 0;
        chk(req, tx_req, (ech >= 0));
        if (ech >= 0) chk(req, tx_req_chan, ech);
        @(negedge clk);
        chk(req, tx_out_valid, 1);
        chk(req, tx_out_byte, (ech >= 0) ? expect_byte(src_of(6'(ech)), ech) : 8'hFF);
    endtask

    task automatic example_cfg();
        clear_cfg();
        set_masks(16, 64'hAA, 64'hAA);
        set_masks(17, 64'h55, 64'h55);
        set_masks(19, 64'hFF00, 64'hFF00);
        cfg_rev[16] = 1; cfg_rev[19] = 1; cfg_hdlc[19] = 1;
    endtask

    function automatic int example_owner(int p);
        if (p < 8) return (p % 2 == 1) ? 16 : 17;
        if (p < 16) return 19;
        return -1;
    endfunction

    task automatic test_reset();
        rst = 1;
        repeat (3) @(negedge clk);
        chk("R1 rx idle", ch_rx_valid, 0);
        chk("R1 req idle", tx_req, 0);
        chk("R1 out idle", tx_out_valid, 0);
        rst = 0;
        @(negedge clk);
        chk("R1 after release", {ch_rx_valid, tx_req, tx_out_valid}, 0);
    endtask

    task automatic test_rx_example();
        example_cfg();
        for (int p = 0; p < 18; p++) begin
            rx_slot(p == 0, 8'(8'h81 + p * 13), example_owner(p),
                    (p >= 16) ? "R4 unclaimed rx" : (p >= 8 ? "R6 hdlc rx" : "R2 rx tag"));
        end
    endtask

    task automatic test_restart();
        example_cfg();
        rx_slot(1, 8'h11, 17, "R3 pos0");
        rx_slot(0, 8'h12, 16, "R3 pos1");
        rx_slot(0, 8'h13, 17, "R3 pos2");
        rx_slot(1, 8'h14, 17, "R3 restart pos0");
        rx_slot(0, 8'h15, 16, "R3 restart pos1");
    endtask

    task automatic test_overlap();
        clear_cfg();
        set_masks(2, 64'h4, 64'h4);
        set_masks(5, 64'h4, 64'h4);
        rx_slot(1, 8'h21, -1, "R4 no owner pos0");
        rx_slot(0, 8'h22, -1, "R4 no owner pos1");
        rx_slot(0, 8'h23, 2, "R2 lowest wins");
        cfg_rx_run[2] = 0;
        rx_slot(1, 8'h24, -1, "R5 pos0");
        rx_slot(0, 8'h25, -1, "R5 pos1");
        rx_slot(0, 8'h26, 5, "R5 stopped skipped");
        cfg_rx_run[5] = 0;
        rx_slot(1, 8'h27, -1, "R5 pos0");
        rx_slot(0, 8'h28, -1, "R5 pos1");
        rx_slot(0, 8'h29, -1, "R5 all stopped");
        tx_slot(1, -1, "R8 pos0");
        tx_slot(0, -1, "R8 pos1");
        tx_slot(0, 2, "R7 tx lowest wins");
        cfg_tx_run[2] = 0; cfg_tx_run[5] = 0;
        tx_slot(1, -1, "R8 pos0");
        tx_slot(0, -1, "R8 pos1");
        tx_slot(0, -1, "R8 stopped tx fill");
    endtask

    task automatic test_overflow();
        clear_cfg();
        set_masks(0, 64'h1, 64'h0);
        set_masks(63, 64'h8000_0000_0000_0000, 64'h0);
        for (int p = 0; p < 66; p++) begin
            rx_slot(p == 0, 8'(p), (p == 0) ? 0 : ((p == 63) ? 63 : -1),
                    (p >= 64) ? "R9 past end" : "R3 long frame");
        end
    endtask

    task automatic test_tx_example();
        example_cfg();
        for (int p = 0; p < 17; p++) begin
            tx_slot(p == 0, example_owner(p),
                    (p >= 16) ? "R8 unclaimed tx" : (p >= 8 ? "R6 hdlc tx" : "R7 tx request"));
        end
    endtask

    task automatic test_both();
        example_cfg();
        set_masks(9, 64'h0, 64'h1);
        @(negedge clk);
        rx_strobe = 1; rx_fs = 1; rx_byte = 8'h5A;
        tx_strobe = 1; tx_fs = 1;
        @(negedge clk);
        rx_strobe = 0; rx_fs = 0; tx_strobe = 0; tx_fs = 0;
        chk("R10 rx same cycle", {ch_rx_valid, ch_rx_chan}, {1'b1, 6'd17});
        chk("R10 tx same cycle", {tx_req, tx_req_chan}, {1'b1, 6'd9});
        chk("R10 rx byte", ch_rx_byte, 8'h5A);
        @(negedge clk);
        chk("R10 tx out", {tx_out_valid, tx_out_byte}, {1'b1, src_of(6'd9)});
        rx_slot(0, 8'h66, 16, "R10 rx pos1");
        rx_slot(0, 8'h67, 17, "R10 rx pos2");
        tx_slot(0, 16, "R10 tx pos1 independent");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        test_reset();
        test_rx_example();
        test_restart();
        test_overlap();
        test_overflow();
        test_tx_example();
        test_both();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule